// File: doc/BRIEF.md
# Multi-Function Auxiliary Output Pins

This block drives five auxiliary output pins of a display controller from one 4 MHz oscillator. Each pin has its own function multiplexer. The pins are one converter-pump pin, two filament-phase pins and two general ports. A pin can carry one of the following:

- a fixed divided clock;
- serial data passed through from the serial interface;
- the blink phase;
- the shutdown state;
- a plain logic level.

The serial data, the blink phase and the shutdown state arrive as inputs from neighbouring logic. This block only routes and retimes them.

A small write port loads each pin's configuration. The configuration is a 3-bit function code and a level bit. A single shared prescaler produces every divided clock:

- a 25-cycle sub-counter advances an 8-bit tick counter;
- the pump, filament and buzzer clocks are individual bits of that tick counter.

Every pin output is registered. A change of function therefore never produces a runt pulse.

Top module: `aux_output_ports`

## Requirements
- R1: While reset is held, and on the first edge after it is released, every pin is low. Reset leaves every pin configured as function 0 (plain level) with level 0.
- R2: A pin with function code 0 drives its stored level bit.
- R3: The pump pin (index 0) with function code 4 is a clock of period 50 cycles. It is low for the first 25 cycles of each period, counted from the first edge after reset.
- R4: The two phase pins (indices 1 and 2) with function code 4 carry a clock of period 400 cycles. Pin 1 is low for the first 200 cycles of each period and pin 2 is its complement, so the two are always in antiphase.
- R5: A port pin (index 3 or 4) is a buzzer clock for function codes 5, 6 and 7. The periods are 1600, 3200 and 6400 cycles respectively, each low for the first half of its period.
- R6: The pump pin and the port pins with function code 1 drive the serial data input.
- R7: The phase pins and the port pins with function code 2 drive the blink input.
- R8: The port pins with function code 3 drive the shutdown input.
- R9: A function code that a pin does not support makes that pin drive its level bit. The unsupported codes are 2, 3, 5, 6 and 7 on the pump pin, 1, 3, 5, 6 and 7 on the phase pins, and 4 on the port pins.
- R10: A configuration write sampled on one edge changes the pin on the next edge. Input data (serial, blink, shutdown) sampled on an edge appears on the pin after that same edge.
- R11: A write changes only the addressed pin. A write with pin index 5, 6 or 7 changes no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock (4 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| cfgWrite | input | 1 | Configuration write strobe |
| cfgPort | input | 3 | Pin index for the write: 0 pump, 1 and 2 phase, 3 and 4 port |
| cfgFunc | input | 3 | Function code to store |
| cfgLevel | input | 1 | Level bit to store |
| serialIn | input | 1 | Serial data from the interface |
| blinkIn | input | 1 | Blink phase |
| shutdownIn | input | 1 | Shutdown state |
| pumpOut | output | 1 | Pump pin |
| phase1Out | output | 1 | First filament-phase pin |
| phase2Out | output | 1 | Second filament-phase pin |
| port0Out | output | 1 | First general port pin |
| port1Out | output | 1 | Second general port pin |

## Verification
Data routed through a pin is due one edge after the input is sampled. A configuration write is due two edges after it is driven: one edge to store it and one edge to register the pin.

The bench drives inputs at the falling edge. At each rising edge, a reference model computes the value each pin must register. That value is formed from the configuration and inputs present at the edge, and the clock levels come from integer division of the count of edges since reset. The bench compares the model's values at the next falling edge, so every comparison lands in the cycle its result is due.

Directed checks hold the write-latency and ignored-index cases to the exact cycle. Long phases with all clocks enabled span complete periods of the slowest buzzer clock.

// File: rtl/aux_port_pkg.sv
package aux_port_pkg;

  localparam int NUM_PINS = 5;
  localparam int FUNC_W   = 3;

  // pin kinds: which functions a pin supports
  localparam int KIND_PUMP  = 0;
  localparam int KIND_PHASE = 1;
  localparam int KIND_PORT  = 2;

  typedef enum logic [FUNC_W-1:0] {
    FN_GPIO      = 3'd0,
    FN_SERIAL    = 3'd1,
    FN_BLINK     = 3'd2,
    FN_SHUTDOWN  = 3'd3,
    FN_CLOCK     = 3'd4,
    FN_BUZZ_FAST = 3'd5,
    FN_BUZZ_MID  = 3'd6,
    FN_BUZZ_SLOW = 3'd7
  } portFunc_e;

  // clock levels handed from the control to the datapath
  typedef struct packed {
    logic pumpClk;
    logic pwmClk;
    logic buzzFast;
    logic buzzMid;
    logic buzzSlow;
  } clkStrobes_t;

  function automatic int kindOf(input int pin);
    if (pin == 0) return KIND_PUMP;
    if (pin <= 2) return KIND_PHASE;
    return KIND_PORT;
  endfunction

endpackage

// File: rtl/aux_port_ctrl.sv
module aux_port_ctrl
  import aux_port_pkg::*;
#(
  parameter int PUMP_DIV      = 50,
  parameter int PWM_DIV       = 400,
  parameter int BUZZ_FAST_DIV = 1600,
  parameter int PIN_SEL_W     = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfgWrite,
  input  logic [PIN_SEL_W-1:0]       cfgPort,
  input  logic [FUNC_W-1:0]          cfgFunc,
  input  logic                       cfgLevel,
  output clkStrobes_t                strobes,
  output logic [NUM_PINS*FUNC_W-1:0] cfgFuncQ,
  output logic [NUM_PINS-1:0]        cfgLevelQ
);

  // The prescaler counts half periods of the pump clock. Every slower clock
  // is a power-of-two multiple of it, so each one is a single tick bit.
  localparam int HALF_PUMP = PUMP_DIV / 2;
  localparam int SUB_W     = (HALF_PUMP > 1) ? $clog2(HALF_PUMP) : 1;
  localparam int PWM_BIT   = $clog2(PWM_DIV / PUMP_DIV);
  localparam int FAST_BIT  = $clog2(BUZZ_FAST_DIV / PUMP_DIV);
  localparam int MID_BIT   = FAST_BIT + 1;
  localparam int SLOW_BIT  = FAST_BIT + 2;
  localparam int TICK_W    = SLOW_BIT + 1;

  logic [SUB_W-1:0]  subCnt;
  logic [TICK_W-1:0] tickCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      subCnt  <= '0;
      tickCnt <= '0;
    end else if (subCnt == SUB_W'(HALF_PUMP - 1)) begin
      subCnt  <= '0;
      tickCnt <= tickCnt + 1'b1;
    end else begin
      subCnt  <= subCnt + 1'b1;
    end
  end

  assign strobes.pumpClk  = tickCnt[0];
  assign strobes.pwmClk   = tickCnt[PWM_BIT];
  assign strobes.buzzFast = tickCnt[FAST_BIT];
  assign strobes.buzzMid  = tickCnt[MID_BIT];
  assign strobes.buzzSlow = tickCnt[SLOW_BIT];

  // per-pin configuration registers
  logic [FUNC_W-1:0] funcReg [NUM_PINS];
  logic [NUM_PINS-1:0] levelReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PINS; i++) funcReg[i] <= FN_GPIO;
      levelReg <= '0;
    end else if (cfgWrite) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (cfgPort == PIN_SEL_W'(i)) begin
          funcReg[i]  <= cfgFunc;
          levelReg[i] <= cfgLevel;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : gFlat
    assign cfgFuncQ[g*FUNC_W +: FUNC_W] = funcReg[g];
  end
  assign cfgLevelQ = levelReg;

endmodule

// File: rtl/aux_pin_mux.sv
module aux_pin_mux
  import aux_port_pkg::*;
#(
  parameter int   KIND       = KIND_PORT,
  parameter logic INVERT_PWM = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  clkStrobes_t       strobes,
  input  logic [FUNC_W-1:0] func,
  input  logic              level,
  input  logic              serialIn,
  input  logic              blinkIn,
  input  logic              shutdownIn,
  output logic              pinOut
);

  logic pinNext;

  always_comb begin
    pinNext = level;
    case (func)
      FN_SERIAL:    if (KIND != KIND_PHASE) pinNext = serialIn;
      FN_BLINK:     if (KIND != KIND_PUMP)  pinNext = blinkIn;
      FN_SHUTDOWN:  if (KIND == KIND_PORT)  pinNext = shutdownIn;
      FN_CLOCK: begin
        if (KIND == KIND_PUMP)  pinNext = strobes.pumpClk;
        if (KIND == KIND_PHASE) pinNext = strobes.pwmClk ^ INVERT_PWM;
      end
      FN_BUZZ_FAST: if (KIND == KIND_PORT)  pinNext = strobes.buzzFast;
      FN_BUZZ_MID:  if (KIND == KIND_PORT)  pinNext = strobes.buzzMid;
      FN_BUZZ_SLOW: if (KIND == KIND_PORT)  pinNext = strobes.buzzSlow;
      default:      pinNext = level;
    endcase
  end

  // registered pin: a function change never leaves a runt pulse
  always_ff @(posedge clk) begin
    if (rst) pinOut <= 1'b0;
    else     pinOut <= pinNext;
  end

endmodule

// File: rtl/aux_port_datapath.sv
module aux_port_datapath
  import aux_port_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  clkStrobes_t                strobes,
  input  logic [NUM_PINS*FUNC_W-1:0] cfgFuncQ,
  input  logic [NUM_PINS-1:0]        cfgLevelQ,
  input  logic                       serialIn,
  input  logic                       blinkIn,
  input  logic                       shutdownIn,
  output logic [NUM_PINS-1:0]        pinsOut
);

  for (genvar g = 0; g < NUM_PINS; g++) begin : gPin
    aux_pin_mux #(
      .KIND      (kindOf(g)),
      .INVERT_PWM(g == 2)
    ) uMux (
      .clk       (clk),
      .rst       (rst),
      .strobes   (strobes),
      .func      (cfgFuncQ[g*FUNC_W +: FUNC_W]),
      .level     (cfgLevelQ[g]),
      .serialIn  (serialIn),
      .blinkIn   (blinkIn),
      .shutdownIn(shutdownIn),
      .pinOut    (pinsOut[g])
    );
  end

endmodule

// File: rtl/aux_output_ports.sv
module aux_output_ports
  import aux_port_pkg::*;
#(
  parameter int PUMP_DIV      = 50,
  parameter int PWM_DIV       = 400,
  parameter int BUZZ_FAST_DIV = 1600
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfgWrite,
  input  logic [2:0] cfgPort,
  input  logic [2:0] cfgFunc,
  input  logic       cfgLevel,
  input  logic       serialIn,
  input  logic       blinkIn,
  input  logic       shutdownIn,
  output logic       pumpOut,
  output logic       phase1Out,
  output logic       phase2Out,
  output logic       port0Out,
  output logic       port1Out
);

  clkStrobes_t                strobes;
  logic [NUM_PINS*FUNC_W-1:0] cfgFuncQ;
  logic [NUM_PINS-1:0]        cfgLevelQ;
  logic [NUM_PINS-1:0]        pinsOut;

  aux_port_ctrl #(
    .PUMP_DIV     (PUMP_DIV),
    .PWM_DIV      (PWM_DIV),
    .BUZZ_FAST_DIV(BUZZ_FAST_DIV),
    .PIN_SEL_W    (3)
  ) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .cfgWrite (cfgWrite),
    .cfgPort  (cfgPort),
    .cfgFunc  (cfgFunc),
    .cfgLevel (cfgLevel),
    .strobes  (strobes),
    .cfgFuncQ (cfgFuncQ),
    .cfgLevelQ(cfgLevelQ)
  );

  aux_port_datapath uData (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .cfgFuncQ  (cfgFuncQ),
    .cfgLevelQ (cfgLevelQ),
    .serialIn  (serialIn),
    .blinkIn   (blinkIn),
    .shutdownIn(shutdownIn),
    .pinsOut   (pinsOut)
  );

  assign pumpOut   = pinsOut[0];
  assign phase1Out = pinsOut[1];
  assign phase2Out = pinsOut[2];
  assign port0Out  = pinsOut[3];
  assign port1Out  = pinsOut[4];

endmodule

// File: rtl/aux_port_checker.sv
module aux_port_checker
  import aux_port_pkg::*;
(
  input logic                       clk,
  input logic                       rst,
  input logic                       serialIn,
  input logic                       blinkIn,
  input logic                       shutdownIn,
  input logic                       pumpOut,
  input logic                       phase1Out,
  input logic                       phase2Out,
  input logic                       port0Out,
  input logic                       port1Out,
  input logic [NUM_PINS*FUNC_W-1:0] cfgFuncQ,
  input logic [NUM_PINS-1:0]        cfgLevelQ
);

  assert_reset_low_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> {pumpOut, phase1Out, phase2Out, port0Out, port1Out} == 5'b0);

  assert_gpio_level_R2: assert property (@(posedge clk) disable iff (rst)
    $past(cfgFuncQ[2:0] == FN_GPIO) |-> pumpOut == $past(cfgLevelQ[0]));

  assert_phase_antiphase_R4: assert property (@(posedge clk) disable iff (rst)
    $past(cfgFuncQ[5:3] == FN_CLOCK && cfgFuncQ[8:6] == FN_CLOCK)
      |-> phase1Out != phase2Out);

  assert_serial_pump_R6: assert property (@(posedge clk) disable iff (rst)
    $past(cfgFuncQ[2:0] == FN_SERIAL) |-> pumpOut == $past(serialIn));

  assert_blink_phase_R7: assert property (@(posedge clk) disable iff (rst)
    $past(cfgFuncQ[5:3] == FN_BLINK) |-> phase1Out == $past(blinkIn));

  assert_shutdown_port_R8: assert property (@(posedge clk) disable iff (rst)
    $past(cfgFuncQ[14:12] == FN_SHUTDOWN) |-> port1Out == $past(shutdownIn));

endmodule

bind aux_output_ports aux_port_checker uChk (
  .clk       (clk),
  .rst       (rst),
  .serialIn  (serialIn),
  .blinkIn   (blinkIn),
  .shutdownIn(shutdownIn),
  .pumpOut   (pumpOut),
  .phase1Out (phase1Out),
  .phase2Out (phase2Out),
  .port0Out  (port0Out),
  .port1Out  (port1Out),
  .cfgFuncQ  (cfgFuncQ),
  .cfgLevelQ (cfgLevelQ)
);

// File: tb/tb_aux_output_ports.sv
`timescale 1ns/1ps
module tb_aux_output_ports;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgWrite = 1'b0;
  logic [2:0] cfgPort = '0;
  logic [2:0] cfgFunc = '0;
  logic cfgLevel = 1'b0;
  logic serialIn = 1'b0, blinkIn = 1'b0, shutdownIn = 1'b0;
  logic pumpOut, phase1Out, phase2Out, port0Out, port1Out;

  always #2.5 clk = ~clk;  // 200 MHz

  aux_output_ports dut (
    .clk(clk), .rst(rst), .cfgWrite(cfgWrite), .cfgPort(cfgPort),
    .cfgFunc(cfgFunc), .cfgLevel(cfgLevel), .serialIn(serialIn),
    .blinkIn(blinkIn), .shutdownIn(shutdownIn), .pumpOut(pumpOut),
    .phase1Out(phase1Out), .phase2Out(phase2Out), .port0Out(port0Out),
    .port1Out(port1Out)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // reference model state
  int  edges = 0;
  int  mFunc [5];
  bit  mLevel [5];
  bit  expPin [5];
  bit  checkEn = 1'b0;

  function automatic bit clkBit(int n, int halfPeriod);
    return ((n / halfPeriod) % 2) == 1;
  endfunction

  // expected pin value from the requirement text (R2..R9)
  function automatic bit model(int p, int f, bit lvl, bit ser, bit bl, bit sd, int n);
    bit isPump = (p == 0);
    bit isPhase = (p == 1 || p == 2);
    bit isPort = (p >= 3);
    case (f)
      1: return (isPump || isPort) ? ser : lvl;
      2: return (isPhase || isPort) ? bl : lvl;
      3: return isPort ? sd : lvl;
      4: if (isPump) return clkBit(n, 25);
         else if (p == 1) return clkBit(n, 200);
         else if (p == 2) return !clkBit(n, 200);
         else return lvl;
      5: return isPort ? clkBit(n, 800) : lvl;
      6: return isPort ? clkBit(n, 1600) : lvl;
      7: return isPort ? clkBit(n, 3200) : lvl;
      default: return lvl;
    endcase
  endfunction

  function automatic string tagFor(int p, int f);
    bit isPump = (p == 0);
    bit isPhase = (p == 1 || p == 2);
    case (f)
      0: return "R2";
      1: return isPhase ? "R9" : "R6";
      2: return isPump ? "R9" : "R7";
      3: return (p >= 3) ? "R8" : "R9";
      4: return isPump ? "R3" : (isPhase ? "R4" : "R9");
      default: return (p >= 3) ? "R5" : "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      edges = 0;
      for (int i = 0; i < 5; i++) begin
        mFunc[i] = 0; mLevel[i] = 1'b0; expPin[i] = 1'b0;
      end
    end else begin
      for (int i = 0; i < 5; i++)
        expPin[i] = model(i, mFunc[i], mLevel[i], serialIn, blinkIn, shutdownIn, edges);
      if (cfgWrite && cfgPort < 5) begin
        mFunc[cfgPort]  = int'(cfgFunc);
        mLevel[cfgPort] = cfgLevel;
      end
      edges++;
    end
  end

  function automatic bit pinVal(int p);
    case (p)
      0: return pumpOut;
      1: return phase1Out;
      2: return phase2Out;
      3: return port0Out;
      default: return port1Out;
    endcase
  endfunction

  task automatic check(string tag, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at edge %0d", tag, what, act, exp, edges);
    end
  endtask

  // continuous model comparison, away from the active edge
  always @(negedge clk) begin
    if (checkEn && !rst) begin
      for (int p = 0; p < 5; p++)
        check(tagFor(p, mFuncAtEdge[p]), $sformatf("pin %0d", p), pinVal(p), expPin[p]);
    end
  end

  // function each pin had when its expected value was formed
  int mFuncAtEdge [5];
  always @(posedge clk) begin
    for (int i = 0; i < 5; i++) mFuncAtEdge[i] <= mFunc[i];
  end

  task automatic writeCfg(int p, int f, bit lvl);
    cfgWrite = 1'b1; cfgPort = 3'(p); cfgFunc = 3'(f); cfgLevel = lvl;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic holdRandom(int n);
    for (int k = 0; k < n; k++) begin
      serialIn   = 1'($urandom());
      blinkIn    = 1'($urandom());
      shutdownIn = 1'($urandom());
      @(negedge clk);
    end
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: pins low during reset
    check("R1", "pump in reset", pumpOut, 1'b0);
    check("R1", "phase1 in reset", phase1Out, 1'b0);
    check("R1", "port1 in reset", port1Out, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "pins after first edge", |{pumpOut, phase1Out, phase2Out, port0Out, port1Out}, 1'b0);
    checkEn = 1'b1;
    holdRandom(20);

    // R10: write latency is two edges from the driven write
    cfgWrite = 1'b1; cfgPort = 3'd3; cfgFunc = 3'd0; cfgLevel = 1'b1;
    @(negedge clk);
    cfgWrite = 1'b0;
    check("R10", "port0 one edge after write", port0Out, 1'b0);
    @(negedge clk);
    check("R10", "port0 two edges after write", port0Out, 1'b1);
    // R10: routed data appears one edge after sampling
    writeCfg(4, 3, 1'b0);
    @(negedge clk);
    shutdownIn = 1'b1;
    @(negedge clk);
    check("R10", "port1 shutdown one edge later", port1Out, 1'b1);
    shutdownIn = 1'b0;
    @(negedge clk);
    check("R10", "port1 shutdown cleared", port1Out, 1'b0);

    // R11: out-of-range index writes change nothing
    writeCfg(0, 0, 1'b1);
    writeCfg(4, 0, 1'b0);
    holdRandom(3);
    for (int idx = 5; idx < 8; idx++) writeCfg(idx, 0, 1'b0);
    holdRandom(3);
    check("R11", "pump after ignored writes", pumpOut, 1'b1);
    check("R11", "port0 after ignored writes", port0Out, 1'b1);
    check("R11", "port1 after ignored writes", port1Out, 1'b0);
    writeCfg(0, 0, 1'b0);
    writeCfg(3, 0, 1'b0);

    // sweep: every pin, every code, both levels (R2..R9)
    for (int p = 0; p < 5; p++) begin
      for (int f = 0; f < 8; f++) begin
        for (int l = 0; l < 2; l++) begin
          writeCfg(p, f, l[0]);
          holdRandom(260);
        end
      end
      writeCfg(p, 0, 1'b0);
    end

    // all clocks together over full slow-buzzer periods (R3, R4, R5)
    writeCfg(0, 4, 1'b0);
    writeCfg(1, 4, 1'b0);
    writeCfg(2, 4, 1'b0);
    writeCfg(3, 7, 1'b0);
    writeCfg(4, 6, 1'b0);
    holdRandom(13000);
    writeCfg(3, 5, 1'b1);
    writeCfg(4, 7, 1'b1);
    holdRandom(13000);

    checkEn = 1'b0;
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule